// File: doc/BRIEF.md
# Write-Back Direct-Mapped Data Cache Controller

This block sits between a 32-bit processor's load/store port and a shared main memory. It keeps a direct-mapped array of multiword lines, each with a tag, a valid bit and a dirty bit. A processor access that matches a valid line is served at once: a read returns the word in the same cycle, and a write changes only the cached word and marks the line dirty. Main memory sees nothing on a hit.

A miss stalls the processor. If the line being replaced is dirty, the whole line goes to an external write buffer in a single push. If the buffer is full, the push waits until the buffer has freed a slot. The controller then holds off while the buffer is draining to memory, or while the buffer still holds the block being asked for. After that it fills the line word by word through a strobe/cycle/read bus. When the fill is complete, the stalled access is retried as a hit. Writes allocate: a write miss fills the line first and then merges the new word. The processor keeps its request and address steady for as long as the stall is high. The write buffer compares its pending block addresses against that address to drive its match input.

Top module: `wbcache_ctrl`

## Requirements
- R1: Reset clears every valid and dirty bit. While reset is held, `cpu_stall`, `mem_stb` and `wbuf_push` are low. The first access to any line after reset is a miss.
- R2: A line fill drives `mem_stb`, `mem_cyc` and `mem_rd` high together. A request is held, with its address stable, until `mem_ack`. The fill reads all words of the block (4 by default) at the word addresses {tag, index, word, 2'b00}, with words in ascending order.
- R3: A read hit returns the addressed word on `cpu_rdata` in the same cycle, with `cpu_stall` low and no memory or buffer activity.
- R4: A write hit updates only the cached word and marks the line dirty, with no memory access. The new value reads back on the next cycle.
- R5: A write miss to an invalid line does not push to the write buffer. It fills the line from memory and then writes the word.
- R6: A miss on a line that is valid and dirty pushes the victim before any fill request. The push address is {victim tag, index, 4'b0000}. Word w of the block is on `wbuf_block[32*w +: 32]`.
- R7: A miss on a line that is valid but clean, with a different tag, does not push.
- R8: `wbuf_push` is never high while `wbuf_full` is high. An eviction that finds the buffer full stalls with no memory traffic until a slot frees, and then completes.
- R9: While `wbuf_hit` is high, no fill starts. The fill begins after the buffer has written that block, so the fill returns the data that was evicted.
- R10: No fill request starts while `wbuf_busy` is high, so a miss during a buffer write-back stays stalled until that write-back ends.
- R11: `cpu_stall` is high from the cycle a miss is seen until the cycle in which the retried access hits. It is low for hits and when there is no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address, held while stalled |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid when stall is low |
| cpu_stall | output | 1 | Processor must hold its request |
| mem_stb | output | 1 | Memory strobe |
| mem_cyc | output | 1 | Memory bus cycle |
| mem_rd | output | 1 | Memory read select |
| mem_addr | output | 32 | Memory word byte-address |
| mem_rdata | input | 32 | Memory read data |
| mem_ack | input | 1 | Memory acknowledge |
| wbuf_push | output | 1 | Push victim block into the write buffer |
| wbuf_addr | output | 32 | Victim block base address |
| wbuf_block | output | 128 | Victim block, word w at [32*w +: 32] |
| wbuf_full | input | 1 | Write buffer cannot accept a block |
| wbuf_busy | input | 1 | Write buffer is writing a block to memory |
| wbuf_hit | input | 1 | Write buffer holds the block at cpu_addr |

## Verification
A hit's read data and a low stall are due in the same cycle as the request. A written word is due on the read path at the first edge after the write is accepted. A miss completes at the first falling edge at which stall is low again; with the bench memory this is two cycles per word, plus the eviction and the buffer waits. The bench drives each access at a falling edge and polls stall at falling edges. It reads data only after stall has gone low, and drops the request one edge later so that a write commits exactly once. Memory acknowledges and buffer pushes are counted at rising edges across each access, so that each miss can be checked for exactly four reads and for zero or one push. The buffer model changes full, busy and hit only at falling edges, so the controller sees stable values at each rising edge.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_EVICT = 2'd1,
      ST_WAIT  = 2'd2,
      ST_FILL  = 2'd3
   } miss_st_e;
endpackage

// File: rtl/wbc_tag_array.sv
module wbc_tag_array #(
   parameter int IDX_W     = 6,
   parameter int TAG_W     = 22,
   parameter int NUM_LINES = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [TAG_W-1:0] rd_tag,
   output logic             rd_valid,
   output logic             rd_dirty,
   input  logic             fill_done,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic             mark_dirty
);
   logic [NUM_LINES-1:0] valid_q;
   logic [NUM_LINES-1:0] dirty_q;
   logic [TAG_W-1:0]     tag_q [NUM_LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (fill_done) begin
         valid_q[rd_idx] <= 1'b1;
         dirty_q[rd_idx] <= 1'b0;
      end else if (mark_dirty) begin
         dirty_q[rd_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_done) tag_q[rd_idx] <= fill_tag;
   end

   assign rd_tag   = tag_q[rd_idx];
   assign rd_valid = valid_q[rd_idx];
   assign rd_dirty = dirty_q[rd_idx];

   // R1: reset leaves the line state empty
   assert_reset_clears_R1: assert property (@(posedge clk)
      !rst_n |=> (!rd_valid && !rd_dirty));

   // R2: a completed fill leaves the line valid and clean
   assert_fill_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |=> ((rd_idx != $past(rd_idx)) || (rd_valid && !rd_dirty)));
endmodule

// File: rtl/wbc_data_array.sv
module wbc_data_array #(
   parameter int DATA_W    = 32,
   parameter int BLK_WORDS = 4,
   parameter int NUM_LINES = 64,
   localparam int OFF_W    = $clog2(BLK_WORDS),
   localparam int IDX_W    = $clog2(NUM_LINES),
   localparam int BLK_W    = DATA_W * BLK_WORDS
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  idx,
   input  logic [OFF_W-1:0]  rd_off,
   output logic [DATA_W-1:0] rd_word,
   output logic [BLK_W-1:0]  rd_block,
   input  logic              wr_en,
   input  logic [OFF_W-1:0]  wr_off,
   input  logic [DATA_W-1:0] wr_data
);
   for (genvar w = 0; w < BLK_WORDS; w++) begin : g_bank
      logic [DATA_W-1:0] bank_q [NUM_LINES];
      always_ff @(posedge clk) begin
         if (wr_en && (wr_off == OFF_W'(w))) bank_q[idx] <= wr_data;
      end
      assign rd_block[w*DATA_W +: DATA_W] = bank_q[idx];
   end

   assign rd_word = rd_block[rd_off*DATA_W +: DATA_W];
endmodule

// File: rtl/wbc_miss_fsm.sv
module wbc_miss_fsm
   import wbc_pkg::*;
#(
   parameter int OFF_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             hit,
   input  logic             victim_dirty,
   input  logic             wbuf_full,
   input  logic             wbuf_busy,
   input  logic             wbuf_hit,
   input  logic             mem_ack,
   output logic             stall,
   output logic             push,
   output logic             mem_req,
   output logic [OFF_W-1:0] fill_off,
   output logic             fill_we,
   output logic             fill_done
);
   miss_st_e         st_q, st_d;
   logic [OFF_W-1:0] cnt_q;
   logic             miss;

   assign miss = req && !hit && (st_q == ST_IDLE);

   always_comb begin
      st_d      = st_q;
      push      = 1'b0;
      mem_req   = 1'b0;
      fill_we   = 1'b0;
      fill_done = 1'b0;
      case (st_q)
         ST_IDLE:  if (miss) st_d = victim_dirty ? ST_EVICT : ST_WAIT;
         ST_EVICT: if (!wbuf_full) begin
            push = 1'b1;
            st_d = ST_WAIT;
         end
         ST_WAIT:  if (!wbuf_busy && !wbuf_hit) st_d = ST_FILL;
         ST_FILL: begin
            mem_req = 1'b1;
            if (mem_ack) begin
               fill_we = 1'b1;
               if (&cnt_q) begin
                  fill_done = 1'b1;
                  st_d      = ST_IDLE;
               end
            end
         end
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else begin
         st_q <= st_d;
         if (fill_we) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign stall    = miss || (st_q != ST_IDLE);
   assign fill_off = cnt_q;

   // R8: never push into a full buffer
   assert_no_push_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !wbuf_full);

   // R2: a memory request is held until acknowledged
   assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> mem_req);

   // R9 / R10: a fill starts only once the buffer is idle and does not hold the block
   assert_fill_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> $past(!wbuf_busy && !wbuf_hit));

   // R11: any miss traffic happens under stall
   assert_stall_cover_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (push || mem_req) |-> stall);
endmodule

// File: rtl/wbcache_ctrl.sv
module wbcache_ctrl #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int BLK_WORDS = 4,
   parameter int NUM_LINES = 64,
   localparam int BYTE_W   = $clog2(DATA_W / 8),
   localparam int OFF_W    = $clog2(BLK_WORDS),
   localparam int IDX_W    = $clog2(NUM_LINES),
   localparam int TAG_W    = ADDR_W - IDX_W - OFF_W - BYTE_W,
   localparam int BLK_W    = DATA_W * BLK_WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_stall,
   output logic              mem_stb,
   output logic              mem_cyc,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack,
   output logic              wbuf_push,
   output logic [ADDR_W-1:0] wbuf_addr,
   output logic [BLK_W-1:0]  wbuf_block,
   input  logic              wbuf_full,
   input  logic              wbuf_busy,
   input  logic              wbuf_hit
);
   // elaboration-time parameter checks
   if (BLK_WORDS < 2 || (1 << OFF_W) != BLK_WORDS) begin : g_bad_blk
      $error("BLK_WORDS must be a power of two, at least 2");
   end
   if (NUM_LINES < 2 || (1 << IDX_W) != NUM_LINES) begin : g_bad_lines
      $error("NUM_LINES must be a power of two, at least 2");
   end
   if (DATA_W < 8 || (DATA_W % 8) != 0 || (8 << BYTE_W) != DATA_W) begin : g_bad_data
      $error("DATA_W must be a power-of-two number of bytes");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("address too narrow for the chosen geometry");
   end

   logic [TAG_W-1:0] cpu_tag;
   logic [IDX_W-1:0] cpu_idx;
   logic [OFF_W-1:0] cpu_off;
   logic             byte_unused;

   assign cpu_tag     = cpu_addr[ADDR_W-1 -: TAG_W];
   assign cpu_idx     = cpu_addr[BYTE_W+OFF_W +: IDX_W];
   assign cpu_off     = cpu_addr[BYTE_W +: OFF_W];
   assign byte_unused = ^cpu_addr[BYTE_W-1:0];

   logic [TAG_W-1:0] line_tag;
   logic             line_valid, line_dirty;
   logic             hit, wr_hit;
   logic             fill_we, fill_done, mem_req;
   logic [OFF_W-1:0] fill_off;
   logic             dw_en;
   logic [OFF_W-1:0] dw_off;
   logic [DATA_W-1:0] dw_data;

   assign hit    = line_valid && (line_tag == cpu_tag);
   assign wr_hit = cpu_req && cpu_we && !cpu_stall;

   assign dw_en   = fill_we || wr_hit;
   assign dw_off  = fill_we ? fill_off : cpu_off;
   assign dw_data = fill_we ? mem_rdata : cpu_wdata;

   wbc_tag_array #(
      .IDX_W(IDX_W), .TAG_W(TAG_W), .NUM_LINES(NUM_LINES)
   ) tags_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx    (cpu_idx),
      .rd_tag    (line_tag),
      .rd_valid  (line_valid),
      .rd_dirty  (line_dirty),
      .fill_done (fill_done),
      .fill_tag  (cpu_tag),
      .mark_dirty(wr_hit)
   );

   wbc_data_array #(
      .DATA_W(DATA_W), .BLK_WORDS(BLK_WORDS), .NUM_LINES(NUM_LINES)
   ) data_i (
      .clk     (clk),
      .idx     (cpu_idx),
      .rd_off  (cpu_off),
      .rd_word (cpu_rdata),
      .rd_block(wbuf_block),
      .wr_en   (dw_en),
      .wr_off  (dw_off),
      .wr_data (dw_data)
   );

   wbc_miss_fsm #(
      .OFF_W(OFF_W)
   ) fsm_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .req         (cpu_req),
      .hit         (hit),
      .victim_dirty(line_valid && line_dirty),
      .wbuf_full   (wbuf_full),
      .wbuf_busy   (wbuf_busy),
      .wbuf_hit    (wbuf_hit),
      .mem_ack     (mem_ack),
      .stall       (cpu_stall),
      .push        (wbuf_push),
      .mem_req     (mem_req),
      .fill_off    (fill_off),
      .fill_we     (fill_we),
      .fill_done   (fill_done)
   );

   assign mem_stb   = mem_req;
   assign mem_cyc   = mem_req;
   assign mem_rd    = mem_req;
   assign mem_addr  = {cpu_tag, cpu_idx, fill_off, {BYTE_W{1'b0}}};
   assign wbuf_addr = {line_tag, cpu_idx, {(OFF_W+BYTE_W){1'b0}}};

   // R4: a written word is visible on the read path one cycle later
   assert_write_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_we && !cpu_stall) |=>
         ((cpu_addr != $past(cpu_addr)) || (cpu_rdata == $past(cpu_wdata))));

   // R2: fill address stays put while waiting for acknowledge
   assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_stb && !mem_ack) |=> $stable(mem_addr));
endmodule

// File: tb/wbcache_ctrl_tb_top.sv
`timescale 1ns/1ps
module wbcache_ctrl_tb_top;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic         rst_n;
   logic         cpu_req, cpu_we;
   logic [31:0]  cpu_addr, cpu_wdata, cpu_rdata;
   logic         cpu_stall;
   logic         mem_stb, mem_cyc, mem_rd;
   logic [31:0]  mem_addr, mem_rdata;
   logic         mem_ack;
   logic         wbuf_push;
   logic [31:0]  wbuf_addr;
   logic [127:0] wbuf_block;
   logic         wbuf_full, wbuf_busy, wbuf_hit;

   wbcache_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
      .mem_stb(mem_stb), .mem_cyc(mem_cyc), .mem_rd(mem_rd),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .wbuf_push(wbuf_push), .wbuf_addr(wbuf_addr), .wbuf_block(wbuf_block),
      .wbuf_full(wbuf_full), .wbuf_busy(wbuf_busy), .wbuf_hit(wbuf_hit)
   );

   int total = 0;
   int fails = 0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- memory model: ack one cycle after strobe ----------------
   bit [31:0] back_mem [bit [31:0]];

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      if (back_mem.exists(a)) return back_mem[a];
      return a ^ 32'hC0DE_0000;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_ack   <= 1'b0;
         mem_rdata <= '0;
      end else if (mem_stb && !mem_ack) begin
         mem_ack   <= 1'b1;
         mem_rdata <= mem_word(mem_addr);
      end else begin
         mem_ack <= 1'b0;
      end
   end

   // ---------------- monitors (rising edge) ----------------
   int          acks = 0, pushes = 0, proto_err = 0, overlap = 0;
   logic        prev_wait = 1'b0;
   logic [31:0] prev_addr = '0;
   logic        pend_push;
   logic [31:0] pend_addr;
   logic [127:0] pend_blk;

   always @(posedge clk) begin
      if (!rst_n) begin
         pend_push <= 1'b0;
         prev_wait = 1'b0;
      end else begin
         if (mem_ack) acks++;
         if (mem_stb != mem_cyc || mem_stb != mem_rd) proto_err++;
         if (prev_wait && (!mem_stb || mem_addr != prev_addr)) proto_err++;
         prev_wait = mem_stb && !mem_ack;
         prev_addr = mem_addr;
         if (mem_stb && wbuf_busy) overlap++;
         if (wbuf_push) pushes++;
         pend_push <= wbuf_push;
         pend_addr <= wbuf_addr;
         pend_blk  <= wbuf_block;
      end
   end

   // ---------------- write buffer model (falling edge), 2 entries ----------------
   logic [31:0]  wb_a [2];
   logic [127:0] wb_d [2];
   int           wb_n = 0;
   int           dcnt = 0;
   logic         busy_r = 1'b0;
   bit           drain_en = 1'b1;
   int           wb_err = 0;

   always @(negedge clk) begin
      if (!rst_n) begin
         wb_n   = 0;
         busy_r = 1'b0;
         dcnt   = 0;
      end else begin
         if (pend_push) begin
            if (wb_n >= 2) wb_err++;
            else begin
               wb_a[wb_n] = pend_addr;
               wb_d[wb_n] = pend_blk;
               wb_n++;
            end
         end
         if (busy_r) begin
            dcnt--;
            if (dcnt == 0) begin
               for (int w = 0; w < 4; w++) back_mem[wb_a[0] + 32'(4*w)] = wb_d[0][w*32 +: 32];
               wb_a[0] = wb_a[1];
               wb_d[0] = wb_d[1];
               wb_n--;
               busy_r = 1'b0;
            end
         end else if (drain_en && wb_n > 0 && !mem_stb) begin
            busy_r = 1'b1;
            dcnt   = 8;
         end
      end
   end

   assign wbuf_full = (wb_n == 2);
   assign wbuf_busy = busy_r;
   always_comb begin
      wbuf_hit = 1'b0;
      for (int i = 0; i < 2; i++)
         if (i < wb_n && wb_a[i] == (cpu_addr & ~32'hF)) wbuf_hit = 1'b1;
   end

   // ---------------- processor access task ----------------
   task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                         output logic [31:0] rd, output int cyc);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      #1;
      cyc = 0;
      while (cpu_stall && cyc < 2000) begin
         @(negedge clk); #1; cyc++;
      end
      rd = cpu_rdata;
      @(posedge clk); #1;
      cpu_req = 1'b0; cpu_we = 1'b0;
   endtask

   // request held with drain disabled; must stay stalled, then finish after drain
   task automatic stuck_then_release(input logic [31:0] a, input string tag, output logic [31:0] rd);
      int p0, a0, n;
      p0 = pushes; a0 = acks;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
      repeat (20) @(negedge clk);
      #1;
      check(cpu_stall == 1'b1, {tag, " stays stalled"}, 32'(cpu_stall), 32'd1);
      check(pushes == p0 && acks == a0, {tag, " no push or fill while blocked"},
            32'(pushes - p0 + acks - a0), 32'd0);
      @(posedge clk);
      drain_en = 1'b1;
      n = 0;
      do begin
         @(negedge clk); #1; n++;
      end while (cpu_stall && n < 2000);
      rd = cpu_rdata;
      @(posedge clk); #1;
      cpu_req = 1'b0;
   endtask

   // ---------------- vector table ----------------
   typedef struct packed {
      bit          we;
      logic [31:0] addr;
      logic [31:0] wdata;
      bit          chk;
      logic [31:0] exp;
      bit          miss;
      logic [3:0]  acks;
      logic [1:0]  push;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 32'h0000_0010, 32'h0,         1'b1, 32'hC0DE_0010, 1'b1, 4'd4, 2'd0, 4'd1},  // R1 first access misses, R2 fill
      '{1'b0, 32'h0000_0014, 32'h0,         1'b1, 32'hC0DE_0014, 1'b0, 4'd0, 2'd0, 4'd3},  // R3 read hit
      '{1'b1, 32'h0000_0018, 32'h1111_2222, 1'b0, 32'h0,         1'b0, 4'd0, 2'd0, 4'd4},  // R4 write hit
      '{1'b0, 32'h0000_0018, 32'h0,         1'b1, 32'h1111_2222, 1'b0, 4'd0, 2'd0, 4'd4},  // R4 readback
      '{1'b1, 32'h0000_0420, 32'hAAAA_0001, 1'b0, 32'h0,         1'b1, 4'd4, 2'd0, 4'd5},  // R5 write miss, invalid line
      '{1'b0, 32'h0000_0424, 32'h0,         1'b1, 32'hC0DE_0424, 1'b0, 4'd0, 2'd0, 4'd5},  // R5 rest of line filled
      '{1'b0, 32'h0000_0420, 32'h0,         1'b1, 32'hAAAA_0001, 1'b0, 4'd0, 2'd0, 4'd5},  // R5 merged word
      '{1'b0, 32'h0000_0410, 32'h0,         1'b1, 32'hC0DE_0410, 1'b1, 4'd4, 2'd1, 4'd6},  // R6 dirty victim pushed
      '{1'b0, 32'h0000_0018, 32'h0,         1'b1, 32'h1111_2222, 1'b1, 4'd4, 2'd0, 4'd7}   // R7 clean victim, data via buffer
   };

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   // ---------------- main sequence ----------------
   initial begin
      logic [31:0] rd;
      int cyc, a0, p0, ov0;
      rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
      repeat (5) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      check(cpu_stall == 1'b0, "R1 reset stall", 32'(cpu_stall), 32'd0);
      check(mem_stb == 1'b0, "R1 reset mem_stb", 32'(mem_stb), 32'd0);
      check(wbuf_push == 1'b0, "R1 reset push", 32'(wbuf_push), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);

      for (int i = 0; i < NV; i++) begin
         a0 = acks; p0 = pushes;
         access(VECS[i].we, VECS[i].addr, VECS[i].wdata, rd, cyc);
         // R11: stall only on misses
         check((cyc > 0) == VECS[i].miss, $sformatf("R11/R%0d row%0d miss", VECS[i].req, i),
               32'(cyc), 32'(VECS[i].miss));
         if (VECS[i].chk)
            check(rd == VECS[i].exp, $sformatf("R%0d row%0d data", VECS[i].req, i), rd, VECS[i].exp);
         check(acks - a0 == int'(VECS[i].acks), $sformatf("R2/R%0d row%0d fill words", VECS[i].req, i),
               32'(acks - a0), 32'(VECS[i].acks));
         check(pushes - p0 == int'(VECS[i].push), $sformatf("R%0d row%0d pushes", VECS[i].req, i),
               32'(pushes - p0), 32'(VECS[i].push));
      end

      // R6: content of the pushed victim block (last push was the 0x10 block)
      check(pend_addr == 32'h0000_0010, "R6 victim address", pend_addr, 32'h0000_0010);
      check(pend_blk[2*32 +: 32] == 32'h1111_2222, "R6 victim dirty word", pend_blk[2*32 +: 32], 32'h1111_2222);
      check(pend_blk[0 +: 32] == 32'hC0DE_0010, "R6 victim word0", pend_blk[0 +: 32], 32'hC0DE_0010);
      repeat (20) @(posedge clk);

      // R10: miss while the buffer writes back
      drain_en = 1'b0;
      access(1'b1, 32'h0000_00A0, 32'hBEEF_0A00, rd, cyc);
      access(1'b1, 32'h0000_04A4, 32'h5555_04A4, rd, cyc);
      @(posedge clk);
      drain_en = 1'b1;
      ov0 = overlap;
      access(1'b0, 32'h0000_0300, 32'h0, rd, cyc);
      check(cyc >= 10, "R10 stalled through write-back", 32'(cyc), 32'd10);
      check(rd == 32'hC0DE_0300, "R10 data after wait", rd, 32'hC0DE_0300);
      check(overlap == ov0, "R10 no fill during write-back", 32'(overlap - ov0), 32'd0);
      repeat (20) @(posedge clk);

      // R9: wanted block still in the buffer
      drain_en = 1'b0;
      access(1'b0, 32'h0000_00A0, 32'h0, rd, cyc);
      check(rd == 32'hBEEF_0A00, "R9 data back from memory after drain", rd, 32'hBEEF_0A00);
      stuck_then_release(32'h0000_04A4, "R9", rd);
      check(rd == 32'h5555_04A4, "R9 fill sees evicted data", rd, 32'h5555_04A4);
      repeat (30) @(posedge clk);

      // R8: buffer full at eviction
      drain_en = 1'b0;
      access(1'b1, 32'h0000_00B0, 32'h7777_00B0, rd, cyc);
      access(1'b1, 32'h0000_04B0, 32'h7777_04B0, rd, cyc);
      access(1'b1, 32'h0000_00C0, 32'h7777_00C0, rd, cyc);
      access(1'b1, 32'h0000_04C0, 32'h7777_04C0, rd, cyc);
      check(wbuf_full == 1'b1, "R8 buffer filled", 32'(wbuf_full), 32'd1);
      p0 = pushes;
      stuck_then_release(32'h0000_00B0, "R8", rd);
      check(rd == 32'h7777_00B0, "R8 resumed miss data", rd, 32'h7777_00B0);
      check(pushes - p0 == 1, "R8 one push after slot freed", 32'(pushes - p0), 32'd1);
      repeat (40) @(posedge clk);

      // R2 protocol and model sanity
      check(proto_err == 0, "R2 strobe/cycle/read bundle and hold", 32'(proto_err), 32'd0);
      check(wb_err == 0, "R8 no push into full buffer", 32'(wb_err), 32'd0);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule